// File: doc/BRIEF.md
# Polarity-Steered Bidirectional-Switch PWM Generator

This block drives the eight gates of four bidirectional power switches in a hybrid boost switched-capacitor stage. Each switch is a pair of transistors in anti-series, with one gate for each side ("a" and "b"). A free-running carrier counter divides every switching period into two conduction intervals. In the first interval, switches S1 and S3 conduct. In the second, S2 and S4 conduct. A programmable dead time sits at the start of each interval.

The sign of the output voltage decides which transistor of every switch is held on for the whole half-cycle. Only its partner is pulse-width modulated. Because the held transistors stay on through the dead time, the inductor current always has a path, so the stage behaves like a synchronous dc-dc converter.

The period, duty and dead time are counts of the system clock. They are taken, together with the sign, only when a new period begins. A synchronous enable switches every gate off.

Top module: `bidir_pwm_gen`

## Requirements
- R1: While `rst_n` is low, all eight gate outputs are 0.
- R2: If `en` is sampled low at a clock edge, all gates are 0 after that edge. When `en` is sampled high again, the next edge starts a new period at count 0.
- R3: Gate bit i belongs to switch S(i+1). During a period taken with `vo_neg`=0, all four `gate_a` bits are 1 and `gate_b` carries the modulation. With `vo_neg`=1 the roles of the two buses are swapped.
- R4: The modulated gates of S1 and S3 (bits 0 and 2) are on when the count c satisfies dt <= c < d. Here dt is the dead count and d is the clamped duty.
- R5: The modulated gates of S2 and S4 (bits 1 and 3) are on when d+dt <= c < P, where P is the period count.
- R6: The duty used is d = max(2·dt, min(duty, P−dt)). This gives each stage at least one dead time.
- R7: Period, duty, dead and sign are sampled only on the edge that starts a period. Changes made in the middle of a period have no effect until the next period.
- R8: In no cycle do a first-stage switch (S1 or S3) and a second-stage switch (S2 or S4) both have both of their transistors on.
- R9: A running period lasts exactly P cycles. The count then restarts at 0.
- R10: A cycle in which a first-stage switch fully conducts is never directly followed by one in which a second-stage switch fully conducts, and the reverse also holds. Operating contract: dt >= 1 and P >= 3·dt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous run enable |
| vo_neg | input | 1 | Output-voltage sign, 1 = negative half-cycle |
| period_cnt | input | CNT_W | Carrier period P in clock counts |
| duty_cnt | input | CNT_W | First-stage length request in counts |
| dead_cnt | input | CNT_W | Dead time dt in counts |
| gate_a | output | 4 | Side-a gate of S1..S4 (bit 0 = S1) |
| gate_b | output | 4 | Side-b gate of S1..S4 (bit 0 = S1) |

## Verification
Two functions can fall in the same clock edge: the period reload and an enable drop. A sign or duty change can also land on the last count of a period, so the reload and the new sample happen together. The bench times these events from its own count model. It sets `en` low exactly at count P−1, and it flips `vo_neg` and the duty at that count and again mid-period. It then judges every cycle against the behavioural model. Directed checks confirm that a change made mid-period leaves the current waveform untouched, and that the gates go dark on the edge after the drop rather than one period later.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
  localparam int SW_COUNT = 4;

  typedef enum logic [1:0] {
    STG_DEAD   = 2'd0,
    STG_FIRST  = 2'd1,
    STG_SECOND = 2'd2
  } stage_e;

  // Switches S1/S3 (even index) belong to the first stage, S2/S4 to the second.
  function automatic stage_e switch_stage(input int idx);
    return (idx % 2 == 0) ? STG_FIRST : STG_SECOND;
  endfunction
endpackage

// File: rtl/pwmq_frame_latch.sv
module pwmq_frame_latch #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] period_in,
  input  logic [W-1:0] duty_in,
  input  logic [W-1:0] dead_in,
  input  logic         sign_in,
  output logic [W-1:0] period_q,
  output logic [W-1:0] edge_q,
  output logic [W-1:0] dead_q,
  output logic         sign_q
);
  logic [W:0] lo_lim;
  logic [W:0] hi_lim;
  logic [W:0] req;
  logic [W:0] pick;

  always_comb begin
    lo_lim = {dead_in, 1'b0};
    hi_lim = {1'b0, period_in} - {1'b0, dead_in};
    req    = {1'b0, duty_in};
    if (req < lo_lim)      pick = lo_lim;
    else if (req > hi_lim) pick = hi_lim;
    else                   pick = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      edge_q   <= '0;
      dead_q   <= '0;
      sign_q   <= 1'b0;
    end else if (load) begin
      period_q <= period_in;
      edge_q   <= pick[W-1:0];
      dead_q   <= dead_in;
      sign_q   <= sign_in;
    end
  end
endmodule

// File: rtl/pwmq_carrier.sv
module pwmq_carrier #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] period_q,
  output logic [W-1:0] cnt_q,
  output logic         run_q,
  output logic         load
);
  logic at_end;

  assign at_end = (cnt_q == period_q - 1'b1);
  assign load   = en & (~run_q | at_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwmq_gate_map.sv
module pwmq_gate_map
  import pwmq_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                run,
  input  logic                sign,
  input  logic [W-1:0]        cnt,
  input  logic [W-1:0]        edge_cnt,
  input  logic [W-1:0]        dead,
  input  logic [W-1:0]        period,
  output logic [SW_COUNT-1:0] gate_a,
  output logic [SW_COUNT-1:0] gate_b
);
  logic   [W:0] second_start;
  stage_e       now_stage;

  always_comb begin
    second_start = {1'b0, edge_cnt} + {1'b0, dead};
    if ((cnt >= dead) && (cnt < edge_cnt))
      now_stage = STG_FIRST;
    else if (({1'b0, cnt} >= second_start) && (cnt < period))
      now_stage = STG_SECOND;
    else
      now_stage = STG_DEAD;
  end

  for (genvar i = 0; i < SW_COUNT; i++) begin : g_sw
    localparam stage_e MY_STAGE = switch_stage(i);
    logic mod_on;
    assign mod_on    = (now_stage == MY_STAGE);
    assign gate_a[i] = run & (sign ? mod_on : 1'b1);
    assign gate_b[i] = run & (sign ? 1'b1 : mod_on);
  end
endmodule

// File: rtl/bidir_pwm_gen.sv
module bidir_pwm_gen
  import pwmq_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             vo_neg,
  input  logic [CNT_W-1:0] period_cnt,
  input  logic [CNT_W-1:0] duty_cnt,
  input  logic [CNT_W-1:0] dead_cnt,
  output logic [3:0]       gate_a,
  output logic [3:0]       gate_b
);
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] edge_q;
  logic [CNT_W-1:0] dead_q;
  logic             sign_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             load;

  pwmq_carrier #(.W(CNT_W)) u_carrier (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .period_q (period_q),
    .cnt_q    (cnt_q),
    .run_q    (run_q),
    .load     (load)
  );

  pwmq_frame_latch #(.W(CNT_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .period_in (period_cnt),
    .duty_in   (duty_cnt),
    .dead_in   (dead_cnt),
    .sign_in   (vo_neg),
    .period_q  (period_q),
    .edge_q    (edge_q),
    .dead_q    (dead_q),
    .sign_q    (sign_q)
  );

  pwmq_gate_map #(.W(CNT_W)) u_map (
    .run      (run_q),
    .sign     (sign_q),
    .cnt      (cnt_q),
    .edge_cnt (edge_q),
    .dead     (dead_q),
    .period   (period_q),
    .gate_a   (gate_a),
    .gate_b   (gate_b)
  );
endmodule

// File: rtl/pwmq_checker.sv
module pwmq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [3:0] gate_a,
  input logic [3:0] gate_b
);
  logic first_full;
  logic second_full;
  assign first_full  = (gate_a[0] & gate_b[0]) | (gate_a[2] & gate_b[2]);
  assign second_full = (gate_a[1] & gate_b[1]) | (gate_a[3] & gate_b[3]);

  assert_stage_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(first_full && second_full));

  assert_enable_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (gate_a == 4'b0 && gate_b == 4'b0));

  assert_held_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|{gate_a, gate_b}) |-> ((&gate_a) != (&gate_b)));

  assert_pair_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_a[0] == gate_a[2]) && (gate_b[0] == gate_b[2]) &&
    (gate_a[1] == gate_a[3]) && (gate_b[1] == gate_b[3]));

  assert_dead_gap_fwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    first_full |=> !second_full);

  assert_dead_gap_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
    second_full |=> !first_full);
endmodule

bind bidir_pwm_gen pwmq_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en     (en),
  .gate_a (gate_a),
  .gate_b (gate_b)
);

// File: tb/bidir_pwm_gen_bench.sv
module bidir_pwm_gen_bench;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic         vo_neg = 1'b0;
  logic [W-1:0] period_cnt = 12'd40;
  logic [W-1:0] duty_cnt = 12'd20;
  logic [W-1:0] dead_cnt = 12'd3;
  logic [3:0]   gate_a;
  logic [3:0]   gate_b;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bidir_pwm_gen #(.CNT_W(W)) u_bidir_pwm_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .vo_neg(vo_neg),
    .period_cnt(period_cnt), .duty_cnt(duty_cnt), .dead_cnt(dead_cnt),
    .gate_a(gate_a), .gate_b(gate_b)
  );

  // behavioural reference
  int m_run = 0, m_cnt = 0, m_p = 0, m_d = 0, m_dt = 0, m_sg = 0;

  function automatic int clamp_duty(int p, int du, int dt);
    int lo = 2 * dt;
    int hi = p - dt;
    if (du < lo) return lo;
    if (du > hi) return hi;
    return du;
  endfunction

  always @(posedge clk) begin
    if (!rst_n || !en) begin
      m_run = 0; m_cnt = 0;
    end else if (m_run == 0 || m_cnt == m_p - 1) begin
      m_p = period_cnt; m_dt = dead_cnt; m_sg = vo_neg;
      m_d = clamp_duty(int'(period_cnt), int'(duty_cnt), int'(dead_cnt));
      m_cnt = 0; m_run = 1;
    end else begin
      m_cnt = m_cnt + 1;
    end
  end

  function automatic logic [3:0] exp_mod();
    logic [3:0] v = 4'b0;
    if (m_cnt >= m_dt && m_cnt < m_d) v = 4'b0101;
    else if (m_cnt >= m_d + m_dt && m_cnt < m_p) v = 4'b1010;
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // per-cycle comparison against the model
  logic prev_first = 1'b0, prev_second = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] ea, eb, held_exp, mod_exp, held_act, mod_act;
      logic ff, sf;
      if (m_run == 0) begin
        check(gate_a == 4'b0 && gate_b == 4'b0, "R2", "idle gates",
              {gate_a, gate_b}, 0);
      end else begin
        mod_exp  = exp_mod();
        held_exp = 4'hF;
        held_act = m_sg ? gate_b : gate_a;
        mod_act  = m_sg ? gate_a : gate_b;
        ea = m_sg ? mod_exp : held_exp;
        eb = m_sg ? held_exp : mod_exp;
        check(held_act == held_exp, "R3", "held bus", held_act, held_exp);
        check(mod_act[0] == mod_exp[0] && mod_act[2] == mod_exp[2], "R4",
              "first-stage mod", mod_act, mod_exp);
        check(mod_act[1] == mod_exp[1] && mod_act[3] == mod_exp[3], "R5",
              "second-stage mod", mod_act, mod_exp);
        if (ea != gate_a || eb != gate_b)
          check(0, "R7", "sampled frame", {gate_a, gate_b}, {ea, eb});
      end
      ff = (gate_a[0] & gate_b[0]) | (gate_a[2] & gate_b[2]);
      sf = (gate_a[1] & gate_b[1]) | (gate_a[3] & gate_b[3]);
      check(!(ff && sf), "R8", "stage overlap", {ff, sf}, 0);
      check(!(prev_first && sf) && !(prev_second && ff), "R10", "dead gap",
            {prev_first, prev_second, ff, sf}, 0);
      prev_first = ff; prev_second = sf;
    end
  end

  task automatic wait_cnt(int c);
    do @(negedge clk); while (!(m_run == 1 && m_cnt == c));
  endtask

  // measures widths over one full period starting at count 0
  task automatic measure(int p, int du, int dt, bit neg);
    int w1 = 0, w2 = 0, d, rise0 = -1, rise1 = -1;
    logic prev = 1'b0;
    d = clamp_duty(p, du, dt);
    wait_cnt(0);
    for (int k = 0; k < 2 * p; k++) begin
      logic m0, m1;
      m0 = neg ? gate_a[0] : gate_b[0];
      m1 = neg ? gate_a[1] : gate_b[1];
      if (k < p) begin
        if (m0) w1++;
        if (m1) w2++;
      end
      if (m0 && !prev) begin
        if (rise0 < 0) rise0 = k; else if (rise1 < 0) rise1 = k;
      end
      prev = m0;
      @(negedge clk);
    end
    check(w1 == d - dt, "R6", "first-stage width", w1, d - dt);
    check(w2 == p - d - dt, "R5", "second-stage width", w2, p - d - dt);
    if (d - dt > 0)
      check(rise1 - rise0 == p, "R9", "period length", rise1 - rise0, p);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(gate_a == 4'b0 && gate_b == 4'b0, "R1", "reset gates",
          {gate_a, gate_b}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(gate_a == 4'b0 && gate_b == 4'b0, "R2", "disabled gates",
          {gate_a, gate_b}, 0);
    en = 1'b1;
    @(negedge clk);
    check(gate_a == 4'hF && gate_b == 4'h0, "R2", "restart at count 0",
          {gate_a, gate_b}, 8'hF0);
    measure(40, 20, 3, 0);
    duty_cnt = 12'd2;
    measure(40, 2, 3, 0);
    duty_cnt = 12'd100;
    measure(40, 100, 3, 0);
    period_cnt = 12'd30; duty_cnt = 12'd12; dead_cnt = 12'd2; vo_neg = 1'b1;
    measure(30, 12, 2, 1);
    // mid-period change is ignored
    vo_neg = 1'b0; period_cnt = 12'd40; duty_cnt = 12'd20; dead_cnt = 12'd3;
    wait_cnt(0);
    wait_cnt(0);
    wait_cnt(5);
    duty_cnt = 12'd30; vo_neg = 1'b1;
    wait_cnt(25);
    check(gate_a == 4'hF && gate_b == 4'b1010, "R7", "mid-period change",
          {gate_a, gate_b}, 8'hFA);
    // change on the last count takes effect in the next period
    wait_cnt(39);
    duty_cnt = 12'd10; vo_neg = 1'b0;
    @(negedge clk);
    check(gate_a == 4'hF && gate_b == 4'h0, "R7", "reload at boundary",
          {gate_a, gate_b}, 8'hF0);
    wait_cnt(5);
    check(gate_b == 4'b0101, "R7", "new duty applied", gate_b, 4'b0101);
    // enable drop coinciding with reload
    wait_cnt(39);
    en = 1'b0;
    @(negedge clk);
    check(gate_a == 4'b0 && gate_b == 4'b0, "R2", "drop at last count",
          {gate_a, gate_b}, 0);
    repeat (3) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    check(gate_a == 4'hF && gate_b == 4'h0, "R2", "resume dead slot",
          {gate_a, gate_b}, 8'hF0);
    measure(40, 10, 3, 0);
    // sign flip exactly on the last count
    wait_cnt(39);
    vo_neg = 1'b1;
    measure(40, 10, 3, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule